// File: doc/BRIEF.md
# Split-Access 64-Bit Counter Register Bank

This block holds a 64-bit control register and seven 64-bit event counters. Software reaches them over a bus that is only 32 bits wide. Each 64-bit register takes two consecutive word addresses. The word at the lower address carries bits 63..32 and the word at the higher address carries bits 31..0.

A 64-bit write happens in two steps. Writing the lower word only parks the data in a shared staging register. Writing the higher word then loads the staged upper half and the new lower half into the target register, both in the same cycle.

Reads are kept coherent in a similar way. Reading the lower word of a counter captures that counter's low half in a holding register. The following read of the higher word returns the captured half, even if events have moved the live counter in between. A software-reset bit in the control register produces a one-cycle pulse on an output port, and that pulse clears every counter.

The counters are split into two kinds:
- Three request counters, each advanced by a one-cycle event pulse.
- Four byte counters, each adding a 16-bit count on every valid pulse.

Top module: `ctr_regbank`

## Requirements
- R1: All register addresses are byte offsets and must be word aligned. The control register is at 0x000/0x004. Counter i (i = 0..6) is at 0xF00+8*i and 0xF04+8*i. The counter order is: 0 dequeued requests, 1 outbound encrypt requests, 2 inbound decrypt requests, 3 outbound bytes encrypted, 4 outbound bytes protected, 5 inbound bytes decrypted, 6 inbound bytes validated. The lower address of each pair returns bits 63..32 and the higher address returns bits 31..0. Read data appears on `bus_rdata` in the cycle after `bus_rd`. After reset, `bus_rdata` and `swrst_pulse` are 0.
- R2: A write to the lower word of a register changes only the staging register. The register itself keeps its value.
- R3: A write to the higher word loads {staged word, write data} into the register in one cycle. The staging register is zero after reset and keeps its value after a commit.
- R4: A commit to the control register with bit 31 of the low half set drives `swrst_pulse` high for exactly one cycle, starting in the cycle after the commit. Bit 31 then reads back as 0.
- R5: While `swrst_pulse` is high, all counters are cleared to zero on the next edge. This clear takes priority over events and writes.
- R6: Each pulse on `req_evt[k]` adds 1 to request counter k.
- R7: Each pulse on `byte_evt[k]` adds the 16-bit value `byte_cnt[16k+15:16k]` to counter 3+k. The full range up to 0xFFFF is supported.
- R8: Counters wrap modulo 2^64.
- R9: A read of a counter's lower word captures that counter's low half. The next read of the same counter's higher word returns the captured half instead of the live value, and consumes the capture.
- R10: A read of a counter's higher word with no capture pending for that counter returns the live low half.
- R11: Unmapped or misaligned addresses read as zero. Writes to them change neither any register nor the staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| swrst_pulse | output | 1 | One-cycle software reset pulse |
| req_evt | input | 3 | Request event pulses, one per request counter |
| byte_evt | input | 4 | Byte-count valid pulses, one per byte counter |
| byte_cnt | input | 64 | Four packed 16-bit byte counts |

## Verification
The following properties are checked on every cycle:
- The software-reset pulse never lasts more than one cycle, and the counters are zero right after it.
- An unmapped read returns zero.
- Request counter 0 steps by exactly one on an event when no write or clear competes with it.
- A lower-word write to the control register leaves that register unchanged.

Some behaviours need the bench's ordered scenarios instead. These are:
- The coherence of a split read while the live counter keeps moving.
- The consumption of the capture by the higher-word read.
- The persistence of the staging word across commits.
- Wrap-around at 2^64.
- The rule that unmapped writes do not disturb the staging register.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int WORD_W    = 32;
  localparam int REG_W     = 64;
  localparam int CTRL_OFFS = 'h000;
  localparam int CTR_BASE  = 'hF00;
  localparam int SWRST_BIT = 31;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [REG_W-1:0]  reg64_t;
endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode #(
  parameter int ADDR_W  = 12,
  parameter int NUM_CTR = 7,
  parameter int IDX_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ctrl,
  output logic              hit_ctr,
  output logic              hi_word,
  output logic [IDX_W-1:0]  idx
);
  import regbank_pkg::*;

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(CTR_BASE);
  localparam logic [ADDR_W-1:0] CTRL_V = ADDR_W'(CTRL_OFFS);
  localparam logic [ADDR_W-4:0] NUM_V  = (ADDR_W-3)'(NUM_CTR);

  logic [ADDR_W-1:0] off;
  logic              aligned;

  always_comb begin
    off      = addr - BASE_V;
    aligned  = (addr[1:0] == 2'b00);
    hi_word  = addr[2];
    hit_ctrl = aligned && (addr[ADDR_W-1:3] == CTRL_V[ADDR_W-1:3]);
    hit_ctr  = aligned && (addr >= BASE_V) && (off[ADDR_W-1:3] < NUM_V);
    idx      = off[IDX_W+2:3];
  end
endmodule

// File: rtl/ctr_event_counter.sv
module ctr_event_counter #(
  parameter int CNT_W = 64,
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc_val,
  output logic [CNT_W-1:0] cnt
);
  // clear beats load, load beats increment
  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (ld)     cnt <= ld_val;
    else if (inc_en) cnt <= cnt + CNT_W'(inc_val);
  end
endmodule

// File: rtl/ctr_read_capture.sv
module ctr_read_capture #(
  parameter int NUM_CTR = 7,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd,
  input  logic                     hit_ctrl,
  input  logic                     hit_ctr,
  input  logic                     hi_word,
  input  logic [IDX_W-1:0]         idx,
  input  logic [CNT_W-1:0]         ctrl_val,
  input  logic [NUM_CTR*CNT_W-1:0] cnt_flat,
  output logic [CNT_W/2-1:0]       rdata
);
  localparam int HW = CNT_W / 2;

  logic [CNT_W-1:0] live;
  logic [HW-1:0]    snap_lo;
  logic [IDX_W-1:0] snap_idx;
  logic             snap_ok;

  always_comb live = cnt_flat[idx*CNT_W +: CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      snap_lo  <= '0;
      snap_idx <= '0;
      snap_ok  <= 1'b0;
    end else if (rd) begin
      if (hit_ctrl) begin
        rdata <= hi_word ? ctrl_val[HW-1:0] : ctrl_val[CNT_W-1:HW];
      end else if (hit_ctr) begin
        if (!hi_word) begin
          rdata    <= live[CNT_W-1:HW];
          snap_lo  <= live[HW-1:0];
          snap_idx <= idx;
          snap_ok  <= 1'b1;
        end else if (snap_ok && (snap_idx == idx)) begin
          rdata   <= snap_lo;
          snap_ok <= 1'b0;
        end else begin
          rdata <= live[HW-1:0];
        end
      end else begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/ctr_regbank.sv
module ctr_regbank #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REQ  = 3,
  parameter int NUM_BYTE = 4,
  parameter int INC_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      swrst_pulse,
  input  logic [NUM_REQ-1:0]        req_evt,
  input  logic [NUM_BYTE-1:0]       byte_evt,
  input  logic [NUM_BYTE*INC_W-1:0] byte_cnt
);
  import regbank_pkg::*;

  localparam int NUM_CTR = NUM_REQ + NUM_BYTE;
  localparam int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam int CNT_W   = REG_W;

  logic             hit_ctrl, hit_ctr, hi_word, addr_hit;
  logic [IDX_W-1:0] idx;
  word_t            stage_q;
  reg64_t           ctrl_q;
  logic             wr_lo, wr_hi;
  logic [NUM_CTR-1:0]       ld_vec;
  logic [NUM_CTR*CNT_W-1:0] cnt_flat;

  ctr_addr_decode #(.ADDR_W(ADDR_W), .NUM_CTR(NUM_CTR), .IDX_W(IDX_W)) dec_i (
    .addr(bus_addr), .hit_ctrl(hit_ctrl), .hit_ctr(hit_ctr),
    .hi_word(hi_word), .idx(idx)
  );

  assign addr_hit    = hit_ctrl | hit_ctr;
  assign wr_lo       = bus_wr & addr_hit & ~hi_word;
  assign wr_hi       = bus_wr & addr_hit & hi_word;
  assign swrst_pulse = ctrl_q[SWRST_BIT];

  // staging word and control register
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_lo) stage_q <= bus_wdata;
      if (wr_hi && hit_ctrl) begin
        ctrl_q            <= {stage_q, bus_wdata};
        ctrl_q[SWRST_BIT] <= bus_wdata[SWRST_BIT] & ~ctrl_q[SWRST_BIT];
      end else begin
        ctrl_q[SWRST_BIT] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic             inc_en;
    logic [INC_W-1:0] inc_val;
    assign ld_vec[i] = wr_hi && hit_ctr && (idx == IDX_W'(i));
    if (i < NUM_REQ) begin : g_req
      assign inc_en  = req_evt[i];
      assign inc_val = INC_W'(1);
    end else begin : g_byte
      assign inc_en  = byte_evt[i-NUM_REQ];
      assign inc_val = byte_cnt[(i-NUM_REQ)*INC_W +: INC_W];
    end
    ctr_event_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) cnt_i (
      .clk(clk), .rst(rst), .clr(swrst_pulse), .ld(ld_vec[i]),
      .ld_val({stage_q, bus_wdata}), .inc_en(inc_en), .inc_val(inc_val),
      .cnt(cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  ctr_read_capture #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W), .CNT_W(CNT_W)) rd_i (
    .clk(clk), .rst(rst), .rd(bus_rd), .hit_ctrl(hit_ctrl), .hit_ctr(hit_ctr),
    .hi_word(hi_word), .idx(idx), .ctrl_val(ctrl_q), .cnt_flat(cnt_flat),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/ctr_regbank_chk.sv
module ctr_regbank_chk #(
  parameter int NUM_CTR = 7,
  parameter int NUM_REQ = 3,
  parameter int CNT_W   = 64
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     swrst_pulse,
  input logic                     bus_rd,
  input logic                     bus_wr,
  input logic                     hi_word,
  input logic                     hit_ctrl,
  input logic                     addr_hit,
  input logic [31:0]              bus_rdata,
  input logic [NUM_REQ-1:0]       req_evt,
  input logic [NUM_CTR-1:0]       ld_vec,
  input logic [63:0]              ctrl_q,
  input logic [NUM_CTR*CNT_W-1:0] cnt_flat
);
  // R4
  swrst_single_chk: assert property (@(posedge clk) disable iff (rst)
    swrst_pulse |=> !swrst_pulse);

  // R5
  swrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    swrst_pulse |=> (cnt_flat == '0));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !addr_hit) |=> (bus_rdata == 32'h0));

  // R6
  req_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (req_evt[0] && !swrst_pulse && !ld_vec[0]) |=>
      (cnt_flat[CNT_W-1:0] == $past(cnt_flat[CNT_W-1:0]) + 1'b1));

  // R2
  stage_only_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_ctrl && !hi_word && !swrst_pulse) |=> $stable(ctrl_q));
endmodule

bind ctr_regbank ctr_regbank_chk #(.NUM_CTR(NUM_CTR), .NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .swrst_pulse(swrst_pulse), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .hi_word(hi_word), .hit_ctrl(hit_ctrl), .addr_hit(addr_hit),
  .bus_rdata(bus_rdata), .req_evt(req_evt), .ld_vec(ld_vec), .ctrl_q(ctrl_q),
  .cnt_flat(cnt_flat)
);

// File: tb/ctr_regbank_tb_top.sv
`timescale 1ns/1ps
module ctr_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        swrst_pulse;
  logic [2:0]  req_evt = '0;
  logic [3:0]  byte_evt = '0;
  logic [63:0] byte_cnt = '0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ctr_regbank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .swrst_pulse(swrst_pulse),
    .req_evt(req_evt), .byte_evt(byte_evt), .byte_cnt(byte_cnt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result one cycle after its strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic req_pulse(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_evt[k] = 1'b1;
      @(negedge clk);
      req_evt[k] = 1'b0;
    end
  endtask

  task automatic byte_pulse(input int k, input logic [15:0] v);
    @(negedge clk);
    byte_evt[k] = 1'b1;
    byte_cnt[k*16 +: 16] = v;
    @(negedge clk);
    byte_evt[k] = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rdata", bus_rdata, 32'h0);
    check("R1 reset pulse", {31'h0, swrst_pulse}, 32'h0);

    // R3: higher-only write after reset commits a zero upper half
    bus_write(12'hF0C, 32'h0000_1234);
    bus_read(12'hF08, 32'h0, "R3 zero staged upper");
    bus_read(12'hF0C, 32'h0000_1234, "R1 low half ctr1");

    // R6 and R10
    req_pulse(0, 5);
    bus_read(12'hF00, 32'h0, "R6 ctr0 upper");
    bus_read(12'hF04, 32'd5, "R6 ctr0 count");
    req_pulse(2, 3);
    bus_read(12'hF14, 32'd3, "R10 live low half ctr2");

    // R2: lower write only stages
    bus_write(12'hF00, 32'h0000_AAAA);
    bus_read(12'hF00, 32'h0, "R2 ctr0 upper unchanged");
    bus_read(12'hF04, 32'd5, "R2 ctr0 lower unchanged");
    bus_write(12'h004, 32'h0000_00FF);
    bus_read(12'h000, 32'h0000_AAAA, "R3 ctrl upper from stage");
    bus_read(12'h004, 32'h0000_00FF, "R3 ctrl lower");
    bus_write(12'h004, 32'h0000_0011);
    bus_read(12'h000, 32'h0000_AAAA, "R3 stage persists");
    bus_read(12'h004, 32'h0000_0011, "R3 ctrl lower again");

    // R7 and R9
    bus_write(12'hF18, 32'h0);
    bus_write(12'hF1C, 32'hFFFF_FFF0);
    byte_pulse(0, 16'h0020);
    bus_read(12'hF18, 32'h1, "R7 carry into upper");
    byte_pulse(0, 16'h0010);
    bus_read(12'hF1C, 32'h10, "R9 snapshot low half");
    bus_read(12'hF1C, 32'h20, "R9 snapshot consumed");
    byte_pulse(3, 16'hFFFF);
    bus_read(12'hF34, 32'h0000_FFFF, "R7 full byte count ctr6");

    // R8 wrap
    bus_write(12'hF08, 32'hFFFF_FFFF);
    bus_write(12'hF0C, 32'hFFFF_FFFF);
    req_pulse(1, 1);
    bus_read(12'hF08, 32'h0, "R8 wrap upper");
    bus_read(12'hF0C, 32'h0, "R8 wrap lower");

    // R11 unmapped
    bus_read(12'hF38, 32'h0, "R11 unmapped read");
    bus_read(12'h010, 32'h0, "R11 gap read");
    bus_read(12'hF02, 32'h0, "R11 misaligned read");
    bus_write(12'hF38, 32'h0000_DEAD);
    bus_write(12'hF2C, 32'h0000_0077);
    bus_read(12'hF28, 32'hFFFF_FFFF, "R11 unmapped write did not stage");
    bus_read(12'hF2C, 32'h0000_0077, "R11 ctr5 lower");

    // R4 and R5 software reset
    bus_write(12'h000, 32'h0);
    bus_write(12'h004, 32'h8000_0000);
    check("R4 pulse high", {31'h0, swrst_pulse}, 32'h1);
    @(negedge clk);
    check("R4 pulse one cycle", {31'h0, swrst_pulse}, 32'h0);
    bus_read(12'hF04, 32'h0, "R5 ctr0 cleared");
    bus_read(12'hF18, 32'h0, "R5 ctr3 upper cleared");
    bus_read(12'hF1C, 32'h0, "R5 ctr3 lower cleared");
    bus_read(12'hF34, 32'h0, "R5 ctr6 cleared");
    bus_read(12'h004, 32'h0, "R4 bit self-cleared");

    repeat (3) @(negedge clk);
    check("R1 queue drained", exp_q.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule